// File: doc/BRIEF.md
# In-Order Completion Controller for Two Execution Units

This block sits between an instruction queue and two execution resources: a single-cycle integer unit and a three-cycle floating-point unit. It takes the instruction at the queue head, sends it to the matching unit in program order, and records it in a small completion queue. Integer and floating-point work may overlap. A younger integer operation can finish before an older floating-point one, but it may not write back first.

Each completion-queue slot stores a finished flag, the result value, the destination register and a fault flag. The execution resources are modelled as a latency plus a value. The value that arrives with the instruction comes back as its result. Each unit returns its completion-queue slot index, and that index marks the matching slot as finished. Only the oldest slot may leave, and at most one leaves per cycle. When the oldest slot is finished, it writes its result. If that slot carries a fault, the block raises the exception instead and does not write. It then drops every queued slot and all unit work still in progress, so no younger instruction has changed architectural state.

Top module: `inord_retire_ctl`

## Requirements
- R1: After reset, `wb_valid`, `exc_valid` and `flush` are 0, and the completion queue is empty.
- R2: An integer instruction that `iq_pop` accepts in cycle T, with no older entry pending, shows `wb_valid` with its `iq_dst` and `iq_data` in cycle T+2.
- R3: A floating-point instruction (`iq_cls` = 1) accepted in cycle T, with no older entry pending, writes back in cycle T+4.
- R4: Once the floating-point unit accepts an instruction in cycle T, it accepts no other until cycle T+3. A floating-point instruction at the queue head waits until then.
- R5: An integer instruction (`iq_cls` = 0) directly behind a floating-point one is accepted in the next cycle, while the floating-point work is still running.
- R6: The completion queue holds 4 entries. While 4 entries are held, `iq_pop` stays 0. An entry frees in the cycle after it writes back or faults.
- R7: Write-backs occur in program order, at most one per cycle. An entry that finishes early writes in the cycle after the next-older entry's write-back or later.
- R8: When the oldest entry is finished and its `iq_exc` flag was set, `exc_valid` and `flush` are 1 for one cycle, `exc_dst` gives its destination, and `wb_valid` is 0 in that cycle.
- R9: No instruction accepted after a faulting one ever writes back, including unit work that was in progress when the flush happened.
- R10: In a flush cycle, `iq_pop` is 0 even when `iq_valid` is 1.
- R11: Instructions are accepted strictly in program order. An instruction that waits at the head blocks every instruction behind it, even one bound for an idle unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iq_valid | input | 1 | Instruction present at the queue head |
| iq_cls | input | 1 | Operation class: 0 integer, 1 floating point |
| iq_dst | input | 5 | Destination register index |
| iq_exc | input | 1 | The instruction will fault |
| iq_data | input | 16 | Value the unit returns as the result |
| iq_pop | output | 1 | Head instruction accepted this cycle |
| int_issue | output | 1 | Integer unit started this cycle |
| fp_issue | output | 1 | Floating-point unit started this cycle |
| wb_valid | output | 1 | Oldest entry writes its result this cycle |
| wb_dst | output | 5 | Destination of the write-back |
| wb_data | output | 16 | Value written back |
| exc_valid | output | 1 | Oldest entry faults this cycle |
| exc_dst | output | 5 | Destination of the faulting entry |
| flush | output | 1 | All entries and unit work are discarded at the end of this cycle |

## Verification
The bench runs every pattern of six integer and floating-point operations, each with no fault and with a fault at every position. For each pattern it predicts, cycle by cycle, when each instruction is accepted, written back or reported. A controller that let a finished integer result bypass an older floating-point one would write back out of order and early. A controller that restarted the busy floating-point unit would report its acceptances and write-backs too soon. Patterns with many operations behind a slow one fill the queue, which catches an off-by-one full test. Fault placements catch a flushed younger result that still writes back, or an instruction taken in the flush cycle.

// File: rtl/irc_pkg.sv
package irc_pkg;

   typedef enum logic {
      CLS_INT = 1'b0,
      CLS_FP  = 1'b1
   } op_cls_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/irc_unit.sv
// Latency model of one execution unit: not pipelined, occupied for LAT cycles.
module irc_unit #(
   parameter int LAT    = 1,
   parameter int TAG_W  = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill,
   input  logic              start,
   input  logic [TAG_W-1:0]  tag_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              ready,
   output logic              res_vld,
   output logic [TAG_W-1:0]  res_tag,
   output logic [DATA_W-1:0] res_data
);

   if (LAT < 1) begin : g_bad_lat
      $error("irc_unit: LAT must be at least 1");
   end

   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q  <= '0;
         data_q <= '0;
      end else if (start) begin
         tag_q  <= tag_in;
         data_q <= data_in;
      end
   end

   assign res_tag  = tag_q;
   assign res_data = data_q;

   if (LAT == 1) begin : g_single
      logic vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) vld_q <= 1'b0;
         else        vld_q <= start & ~kill;
      end
      assign ready   = 1'b1;
      assign res_vld = vld_q;
   end else begin : g_multi
      localparam int CW = $clog2(LAT + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)             cnt_q <= '0;
         else if (kill)          cnt_q <= '0;
         else if (start)         cnt_q <= CW'(LAT);
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign ready   = (cnt_q <= CW'(1));
      assign res_vld = (cnt_q == CW'(1));

      AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q > CW'(1)) && !kill |=> cnt_q == $past(cnt_q) - 1'b1); // R4
   end

   AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ready); // R4

endmodule

// File: rtl/irc_cq.sv
// Completion queue: allocation at the tail, finish marks by slot tag, retire at head.
module irc_cq #(
   parameter int DEPTH  = 4,
   parameter int DST_W  = 5,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc,
   input  logic [DST_W-1:0]  alloc_dst,
   input  logic              alloc_exc,
   output logic [IDX_W-1:0]  alloc_tag,
   output logic              full,
   input  logic              set_a,
   input  logic [IDX_W-1:0]  tag_a,
   input  logic [DATA_W-1:0] data_a,
   input  logic              set_b,
   input  logic [IDX_W-1:0]  tag_b,
   input  logic [DATA_W-1:0] data_b,
   input  logic              retire,
   output logic              head_vld,
   output logic              head_done,
   output logic              head_exc,
   output logic [DST_W-1:0]  head_dst,
   output logic [DATA_W-1:0] head_data
);

   localparam int PTR_W = IDX_W + 1;

   if (!irc_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("irc_cq: DEPTH must be a power of two, at least 2");
   end

   logic [PTR_W-1:0]  hd_q, tl_q;
   logic [PTR_W-1:0]  used;
   logic [DEPTH-1:0]  vld_q, done_q, exc_q;
   logic [DST_W-1:0]  dst_q  [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [IDX_W-1:0]  hd_idx, tl_idx;

   assign hd_idx    = hd_q[IDX_W-1:0];
   assign tl_idx    = tl_q[IDX_W-1:0];
   assign used      = tl_q - hd_q;
   assign full      = (used == PTR_W'(DEPTH));
   assign alloc_tag = tl_idx;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         hd_q <= '0;
         tl_q <= '0;
      end else begin
         if (alloc)  tl_q <= tl_q + 1'b1;
         if (retire) hd_q <= hd_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld_q  <= '0;
         done_q <= '0;
         exc_q  <= '0;
         for (int k = 0; k < DEPTH; k++) begin
            dst_q[k]  <= '0;
            data_q[k] <= '0;
         end
      end else begin
         for (int k = 0; k < DEPTH; k++) begin
            if (alloc && tl_idx == IDX_W'(k)) begin
               vld_q[k]  <= 1'b1;
               done_q[k] <= 1'b0;
               exc_q[k]  <= alloc_exc;
               dst_q[k]  <= alloc_dst;
            end else if (retire && hd_idx == IDX_W'(k)) begin
               vld_q[k]  <= 1'b0;
               done_q[k] <= 1'b0;
            end
            if (set_a && tag_a == IDX_W'(k)) begin
               done_q[k] <= 1'b1;
               data_q[k] <= data_a;
            end
            if (set_b && tag_b == IDX_W'(k)) begin
               done_q[k] <= 1'b1;
               data_q[k] <= data_b;
            end
         end
      end
   end

   assign head_vld  = vld_q[hd_idx];
   assign head_done = done_q[hd_idx];
   assign head_exc  = exc_q[hd_idx];
   assign head_dst  = dst_q[hd_idx];
   assign head_data = data_q[hd_idx];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      used <= PTR_W'(DEPTH)); // R6
   AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !alloc); // R6
   AST_FINISH_LIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
      set_a && !flush |-> vld_q[tag_a]); // R7
   AST_FINISH_LIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
      set_b && !flush |-> vld_q[tag_b]); // R7
   AST_RETIRE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> head_vld && head_done); // R7
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> vld_q == '0); // R9

endmodule

// File: rtl/inord_retire_ctl.sv
module inord_retire_ctl #(
   parameter int DEPTH   = 4,
   parameter int DST_W   = 5,
   parameter int DATA_W  = 16,
   parameter int INT_LAT = 1,
   parameter int FP_LAT  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iq_valid,
   input  logic              iq_cls,
   input  logic [DST_W-1:0]  iq_dst,
   input  logic              iq_exc,
   input  logic [DATA_W-1:0] iq_data,
   output logic              iq_pop,
   output logic              int_issue,
   output logic              fp_issue,
   output logic              wb_valid,
   output logic [DST_W-1:0]  wb_dst,
   output logic [DATA_W-1:0] wb_data,
   output logic              exc_valid,
   output logic [DST_W-1:0]  exc_dst,
   output logic              flush
);

   import irc_pkg::*;

   localparam int IDX_W = $clog2(DEPTH);

   if (FP_LAT < INT_LAT || INT_LAT < 1) begin : g_bad_lat
      $error("inord_retire_ctl: need 1 <= INT_LAT <= FP_LAT");
   end

   logic              cq_full;
   logic [IDX_W-1:0]  slot;
   logic              int_rdy, fp_rdy, unit_rdy;
   logic              int_vld, fp_vld;
   logic [IDX_W-1:0]  int_tag, fp_tag;
   logic [DATA_W-1:0] int_res, fp_res;
   logic              hd_vld, hd_done, hd_exc;
   logic [DST_W-1:0]  hd_dst;
   logic [DATA_W-1:0] hd_data;
   logic              hd_ready;
   op_cls_e           cls;

   assign cls      = op_cls_e'(iq_cls);
   assign unit_rdy = (cls == CLS_FP) ? fp_rdy : int_rdy;
   assign hd_ready = hd_vld & hd_done;

   assign flush     = hd_ready & hd_exc;
   assign exc_valid = flush;
   assign exc_dst   = hd_dst;
   assign wb_valid  = hd_ready & ~hd_exc;
   assign wb_dst    = hd_dst;
   assign wb_data   = hd_data;

   assign iq_pop    = iq_valid & ~cq_full & unit_rdy & ~flush;
   assign int_issue = iq_pop & (cls == CLS_INT);
   assign fp_issue  = iq_pop & (cls == CLS_FP);

   irc_unit #(.LAT(INT_LAT), .TAG_W(IDX_W), .DATA_W(DATA_W)) u_int (
      .clk(clk), .rst_n(rst_n), .kill(flush), .start(int_issue),
      .tag_in(slot), .data_in(iq_data), .ready(int_rdy),
      .res_vld(int_vld), .res_tag(int_tag), .res_data(int_res)
   );

   irc_unit #(.LAT(FP_LAT), .TAG_W(IDX_W), .DATA_W(DATA_W)) u_fp (
      .clk(clk), .rst_n(rst_n), .kill(flush), .start(fp_issue),
      .tag_in(slot), .data_in(iq_data), .ready(fp_rdy),
      .res_vld(fp_vld), .res_tag(fp_tag), .res_data(fp_res)
   );

   irc_cq #(.DEPTH(DEPTH), .DST_W(DST_W), .DATA_W(DATA_W)) u_cq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc(iq_pop), .alloc_dst(iq_dst), .alloc_exc(iq_exc),
      .alloc_tag(slot), .full(cq_full),
      .set_a(int_vld), .tag_a(int_tag), .data_a(int_res),
      .set_b(fp_vld), .tag_b(fp_tag), .data_b(fp_res),
      .retire(hd_ready),
      .head_vld(hd_vld), .head_done(hd_done), .head_exc(hd_exc),
      .head_dst(hd_dst), .head_data(hd_data)
   );

   AST_WB_XOR_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_valid && exc_valid)); // R8
   AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush); // R8
   AST_NO_POP_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !iq_pop); // R10
   AST_NO_WB_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !wb_valid); // R9
   AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({int_issue, fp_issue}) <= 1); // R11
   AST_FP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      fp_issue |=> !fp_issue); // R4

endmodule

// File: tb/sim_inord_retire_ctl.sv
`timescale 1ns/1ps
module sim_inord_retire_ctl;

   localparam int N = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iq_valid = 1'b0, iq_cls = 1'b0, iq_exc = 1'b0;
   logic [4:0]  iq_dst = '0;
   logic [15:0] iq_data = '0;
   logic        iq_pop, int_issue, fp_issue, wb_valid, exc_valid, flush;
   logic [4:0]  wb_dst, exc_dst;
   logic [15:0] wb_data;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   inord_retire_ctl u0 (
      .clk(clk), .rst_n(rst_n), .iq_valid(iq_valid), .iq_cls(iq_cls),
      .iq_dst(iq_dst), .iq_exc(iq_exc), .iq_data(iq_data), .iq_pop(iq_pop),
      .int_issue(int_issue), .fp_issue(fp_issue), .wb_valid(wb_valid),
      .wb_dst(wb_dst), .wb_data(wb_data), .exc_valid(exc_valid),
      .exc_dst(exc_dst), .flush(flush)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog expired: actual 0 expected 1");
      finish_run();
   end

   // One sequence: pattern bit i = 1 means instruction i is floating point.
   // ex = index of the faulting instruction, N = none.
   task automatic run_seq(input int pat, input int ex);
      int    d[N], dn[N], w[N];
      string dtag[N], wtag[N];
      bit    fp[N];
      int    nd, last_fp, lastc, idx, nwb, seen_wb;
      bit    stopped, exc_seen;
      nd = 0; last_fp = -100; lastc = 0;
      for (int i = 0; i < N; i++) fp[i] = pat[i];
      for (int i = 0; i < N; i++) begin
         int c, base;
         base = (i == 0) ? 0 : d[i-1] + 1;
         c = base; dtag[i] = "R11";
         if (i > 0 && fp[i-1] && !fp[i]) dtag[i] = "R5";
         if (fp[i] && last_fp + 3 > c) begin c = last_fp + 3; dtag[i] = "R4"; end
         if (i >= 4 && w[i-4] + 1 > c) begin c = w[i-4] + 1; dtag[i] = "R6"; end
         if (ex < i && c >= w[ex]) break;
         d[i] = c;
         if (fp[i]) last_fp = c;
         dn[i] = c + (fp[i] ? 3 : 1);
         w[i]  = dn[i] + 1;
         wtag[i] = fp[i] ? "R3" : "R2";
         if (i > 0 && w[i-1] + 1 > w[i]) begin w[i] = w[i-1] + 1; wtag[i] = "R7"; end
         nd++;
         if (w[i] > lastc && (ex >= i)) lastc = w[i];
      end
      nwb = (ex < N) ? ex : N;
      idx = 0; seen_wb = 0; stopped = 0; exc_seen = 0;
      for (int c = 0; c <= lastc + 4; c++) begin
         @(negedge clk);
         iq_valid = !stopped && idx < N;
         iq_cls   = (idx < N) ? fp[idx] : 1'b0;
         iq_exc   = (idx == ex);
         iq_dst   = 5'(1 + idx + (pat & 3) * 7);
         iq_data  = 16'(pat * 64 + ex * 8 + idx);
         #1;
         if (exc_valid) begin
            chk(ex < N && c == w[ex], "R8", "fault report cycle", c, (ex < N) ? w[ex] : -1);
            chk(ex < N && exc_dst == 5'(1 + ex + (pat & 3) * 7), "R8", "fault dst",
                int'(exc_dst), 1 + ex + (pat & 3) * 7);
            chk(flush == 1'b1 && wb_valid == 1'b0, "R8", "flush without write",
                int'({flush, wb_valid}), 2);
            if (iq_valid) chk(iq_pop == 1'b0, "R10", "accept during flush", int'(iq_pop), 0);
            exc_seen = 1;
         end
         if (iq_valid && iq_pop && !stopped) begin
            chk(idx < nd && c == d[idx], (idx < nd) ? dtag[idx] : "R11",
                "accept cycle", c, (idx < nd) ? d[idx] : -1);
            chk(int_issue == !fp[idx] && fp_issue == fp[idx], "R11", "unit routing",
                int'({int_issue, fp_issue}), fp[idx] ? 1 : 2);
            idx++;
         end
         if (wb_valid) begin
            if (seen_wb < nwb) begin
               chk(c == w[seen_wb], wtag[seen_wb], "write-back cycle", c, w[seen_wb]);
               chk(wb_dst == 5'(1 + seen_wb + (pat & 3) * 7) &&
                   wb_data == 16'(pat * 64 + ex * 8 + seen_wb), "R7", "write-back order",
                   int'(wb_data), pat * 64 + ex * 8 + seen_wb);
            end else begin
               chk(0, "R9", "write-back of discarded entry", int'(wb_dst), 0);
            end
            seen_wb++;
         end
         if (exc_valid) stopped = 1;
      end
      @(negedge clk);
      iq_valid = 1'b0;
      chk(idx == nd, "R11", "instructions accepted", idx, nd);
      chk(seen_wb == nwb, "R9", "write-back count", seen_wb, nwb);
      chk(exc_seen == (ex < N), "R8", "fault reported", int'(exc_seen), int'(ex < N));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(wb_valid == 0 && exc_valid == 0 && flush == 0, "R1", "outputs in reset",
          int'({wb_valid, exc_valid, flush}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(wb_valid == 0 && exc_valid == 0 && flush == 0, "R1", "outputs after reset",
          int'({wb_valid, exc_valid, flush}), 0);
      iq_valid = 1'b1; iq_cls = 1'b1;
      #1;
      chk(iq_pop == 1'b1 && fp_issue == 1'b1, "R1", "empty queue accepts",
          int'({iq_pop, fp_issue}), 3);
      iq_valid = 1'b0;
      #1;
      for (int p = 0; p < 64; p++)
         for (int e = 0; e <= N; e++)
            run_seq(p, e);
      finish_run();
   end

endmodule